// File: doc/BRIEF.md
# Privilege-Filtered Performance Event Counter Bank

This block holds a small set of performance counters for a processor core: a parameterised number of programmable event counters and one free-running 64-bit cycle counter. Each event counter owns a type register that names the bit of an incoming event vector it watches and carries a set of filter bits. The filter bits decide, from the core's current exception level and security state, whether counting is allowed in that cycle. The cycle counter owns a filter register with the same layout and the same filter rules.

Counting is gated three times over: a master enable in the control register, a per-counter bit in a set-only enable register, and the privilege filter. The core also raises a prohibit input in regions where event counting is not allowed. Event counters never count there. The cycle counter stops there only when the control register's stop bit is set.

Software reaches every register and counter through a 64-bit write port and a registered read port. The address map uses word addresses: event counter n at n, the cycle counter at 31, type register n at 32+n, the cycle filter at 63, the enable-set register at 64 and the control register at 65.

Top module: `pmc_bank`

## Requirements
- R1: After synchronous reset every counter, type register, the cycle filter, the enable-set register and the control register read as zero.
- R2: A read issued with rd_en_i returns the value from before that clock edge on rd_data_o one cycle later. A type or filter register keeps only P (bit 31), NSK (bit 29), NSH (bit 27), M (bit 26), SH (bit 24) and the event number (bits 15:0). All other bits read zero. Enable-set keeps bits 31 and N-1:0. Control keeps bits 0 and 5. Unmapped addresses read zero and ignore writes.
- R3: Event counter n adds 1 in a cycle when evt_i bit (event number of type n) is high and all gates pass. An event number at or above EVT_W, including any with bits 15:10 set, never counts.
- R4: Enable-set bit n gates event counter n and bit 31 gates the cycle counter. A write sets each bit written as 1 and leaves the others unchanged. Only reset clears the register.
- R5: When control bit 0 (master enable) is 0, no counter increments.
- R6: At level 0 the filter always allows counting. At Secure level 1 it allows counting when P=0. At Non-secure level 1 it allows counting when NSK equals P.
- R7: At Non-secure level 2 the filter allows counting when NSH=1. At Secure level 2 it allows counting when SH differs from NSH.
- R8: At level 3 the filter allows counting when M equals P, whatever nsec_i is.
- R9: While prohibit_i is high, no event counter increments. The cycle counter stops under prohibit_i only when control bit 5 is 1.
- R10: The 64-bit cycle counter adds 1 in every cycle in which master enable, enable-set bit 31, its own filter and the prohibit rule all allow counting.
- R11: Event counters wrap from all ones to zero at CNT_W bits. The cycle counter wraps at 64 bits.
- R12: A write to a counter in the same cycle as an increment loads the written value (low CNT_W bits for event counters), and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_i | input | 2 | Current exception level of the core (0 to 3) |
| nsec_i | input | 1 | 1 when the core is in the Non-secure state |
| prohibit_i | input | 1 | 1 in regions where event counting is prohibited |
| evt_i | input | EVT_W | Event pulses for the current cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 7 | Write word address |
| wr_data_i | input | 64 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 7 | Read word address |
| rd_data_o | output | 64 | Registered read data, valid the cycle after rd_en_i |

## Verification
The hardest state to reach from the ports is a filter decision that depends on two bits and the security state together, such as Secure level 2 with SH and NSH set in each combination. The same holds for the interplay of the stop bit and prohibit_i on the cycle counter. The bench sweeps a list of filter words, each written into both a type register and the cycle filter, across all eight level/security pairs while every event line is held high. It then toggles prohibit_i with the stop bit first clear and then set. Wrap-around is reached by preloading counters one or two steps below their limit through the write port. A behavioural model predicts every read on every clock.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int REG_AW     = 7;
  localparam int EVNUM_W    = 16;
  localparam int CYC_IDX    = 31;
  localparam int TYPE_BASE  = 32;
  localparam int FILT_IDX   = 63;
  localparam int ENSET_IDX  = 64;
  localparam int CTRL_IDX   = 65;
  localparam int BIT_P      = 31;
  localparam int BIT_NSK    = 29;
  localparam int BIT_NSH    = 27;
  localparam int BIT_M      = 26;
  localparam int BIT_SH     = 24;
  localparam int BIT_MASTER = 0;
  localparam int BIT_STOP   = 5;

  typedef struct packed {
    logic               p;
    logic               nsk;
    logic               nsh;
    logic               m;
    logic               sh;
    logic [EVNUM_W-1:0] evnum;
  } flt_t;

  function automatic logic [63:0] flt_to_word(flt_t f);
    logic [63:0] w;
    w = '0;
    w[BIT_P]         = f.p;
    w[BIT_NSK]       = f.nsk;
    w[BIT_NSH]       = f.nsh;
    w[BIT_M]         = f.m;
    w[BIT_SH]        = f.sh;
    w[EVNUM_W-1:0]   = f.evnum;
    return w;
  endfunction
endpackage

// File: rtl/pmc_filter.sv
module pmc_filter (
  input  logic [1:0] lvl,
  input  logic       nsec,
  input  logic       p,
  input  logic       nsk,
  input  logic       nsh,
  input  logic       m,
  input  logic       sh,
  output logic       allow
);
  always_comb begin
    unique case (lvl)
      2'd0:    allow = 1'b1;
      2'd1:    allow = nsec ? (nsk == p) : ~p;
      2'd2:    allow = nsec ? nsh : (sh != nsh);
      default: allow = (m == p);
    endcase
  end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= q + W'(1);
  end
endmodule

// File: rtl/pmc_regfile.sv
module pmc_regfile
  import pmc_pkg::*;
#(
  parameter int N_EVT = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [REG_AW-1:0]        wr_addr,
  input  logic [31:0]              wr_data,
  output flt_t [N_EVT-1:0]         evt_flt,
  output flt_t                     cyc_flt,
  output logic [N_EVT-1:0]         en_evt,
  output logic                     en_cyc,
  output logic                     glb_en,
  output logic                     stop_en,
  output logic [N_EVT-1:0]         cnt_ld,
  output logic                     cyc_ld
);
  logic  unused_wd;
  flt_t  wr_flt;

  assign unused_wd = ^wr_data;

  always_comb begin
    wr_flt       = '0;
    wr_flt.p     = wr_data[BIT_P];
    wr_flt.nsk   = wr_data[BIT_NSK];
    wr_flt.nsh   = wr_data[BIT_NSH];
    wr_flt.m     = wr_data[BIT_M];
    wr_flt.sh    = wr_data[BIT_SH];
    wr_flt.evnum = wr_data[EVNUM_W-1:0];
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_type
    assign cnt_ld[g] = wr_en && (wr_addr == REG_AW'(g));
    always_ff @(posedge clk) begin
      if (rst)
        evt_flt[g] <= '0;
      else if (wr_en && wr_addr == REG_AW'(TYPE_BASE + g))
        evt_flt[g] <= wr_flt;
    end
  end

  assign cyc_ld = wr_en && (wr_addr == REG_AW'(CYC_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_flt <= '0;
      en_evt  <= '0;
      en_cyc  <= 1'b0;
      glb_en  <= 1'b0;
      stop_en <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == REG_AW'(FILT_IDX))
        cyc_flt <= wr_flt;
      if (wr_addr == REG_AW'(ENSET_IDX)) begin
        en_evt <= en_evt | wr_data[N_EVT-1:0];
        en_cyc <= en_cyc | wr_data[CYC_IDX];
      end
      if (wr_addr == REG_AW'(CTRL_IDX)) begin
        glb_en  <= wr_data[BIT_MASTER];
        stop_en <= wr_data[BIT_STOP];
      end
    end
  end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int N_EVT = 4,
  parameter int CNT_W = 32,
  parameter int EVT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        lvl_i,
  input  logic              nsec_i,
  input  logic              prohibit_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [63:0]       wr_data_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [63:0]       rd_data_o
);
  localparam int EIDX_W = (EVT_W > 1) ? $clog2(EVT_W) : 1;

  flt_t [N_EVT-1:0]       evt_flt;
  flt_t                   cyc_flt;
  logic [N_EVT-1:0]       en_evt;
  logic                   en_cyc;
  logic                   glb_en;
  logic                   stop_en;
  logic [N_EVT-1:0]       cnt_ld;
  logic                   cyc_ld;
  logic [N_EVT-1:0]       evt_inc;
  logic                   cyc_inc;
  logic                   cyc_allow;
  logic [63:0]            cyc_q;
  logic [CNT_W-1:0]       evt_q [N_EVT];
  logic [N_EVT*CNT_W-1:0] evt_flat;
  logic [63:0]            rd_mux;
  logic                   unused_top;

  assign unused_top = ^wr_data_i[63:32];

  pmc_regfile #(.N_EVT(N_EVT)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i[31:0]),
    .evt_flt (evt_flt),
    .cyc_flt (cyc_flt),
    .en_evt  (en_evt),
    .en_cyc  (en_cyc),
    .glb_en  (glb_en),
    .stop_en (stop_en),
    .cnt_ld  (cnt_ld),
    .cyc_ld  (cyc_ld)
  );

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    logic allow;
    logic in_range;
    logic hit;

    pmc_filter u_flt (
      .lvl   (lvl_i),
      .nsec  (nsec_i),
      .p     (evt_flt[g].p),
      .nsk   (evt_flt[g].nsk),
      .nsh   (evt_flt[g].nsh),
      .m     (evt_flt[g].m),
      .sh    (evt_flt[g].sh),
      .allow (allow)
    );

    assign in_range   = (32'(evt_flt[g].evnum) < 32'(EVT_W));
    assign hit        = in_range && evt_i[evt_flt[g].evnum[EIDX_W-1:0]];
    assign evt_inc[g] = glb_en && en_evt[g] && allow && !prohibit_i && hit;

    pmc_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .ld     (cnt_ld[g]),
      .ld_val (wr_data_i[CNT_W-1:0]),
      .inc    (evt_inc[g]),
      .q      (evt_q[g])
    );

    assign evt_flat[g*CNT_W +: CNT_W] = evt_q[g];
  end

  pmc_filter u_cyc_flt (
    .lvl   (lvl_i),
    .nsec  (nsec_i),
    .p     (cyc_flt.p),
    .nsk   (cyc_flt.nsk),
    .nsh   (cyc_flt.nsh),
    .m     (cyc_flt.m),
    .sh    (cyc_flt.sh),
    .allow (cyc_allow)
  );

  assign cyc_inc = glb_en && en_cyc && cyc_allow && !(stop_en && prohibit_i);

  pmc_counter #(.W(64)) u_cyc (
    .clk    (clk),
    .rst    (rst),
    .ld     (cyc_ld),
    .ld_val (wr_data_i),
    .inc    (cyc_inc),
    .q      (cyc_q)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_addr_i == REG_AW'(ENSET_IDX)) begin
      rd_mux[N_EVT-1:0] = en_evt;
      rd_mux[CYC_IDX]   = en_cyc;
    end else if (rd_addr_i == REG_AW'(CTRL_IDX)) begin
      rd_mux[BIT_MASTER] = glb_en;
      rd_mux[BIT_STOP]   = stop_en;
    end else if (rd_addr_i == REG_AW'(FILT_IDX)) begin
      rd_mux = flt_to_word(cyc_flt);
    end else if (rd_addr_i == REG_AW'(CYC_IDX)) begin
      rd_mux = cyc_q;
    end else begin
      for (int k = 0; k < N_EVT; k++) begin
        if (rd_addr_i == REG_AW'(k))
          rd_mux = 64'(evt_q[k]);
        if (rd_addr_i == REG_AW'(TYPE_BASE + k))
          rd_mux = flt_to_word(evt_flt[k]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_mux;
  end
endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk
  import pmc_pkg::*;
#(
  parameter int N_EVT = 4,
  parameter int CNT_W = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en_i,
  input logic [REG_AW-1:0]        wr_addr_i,
  input logic [63:0]              wr_data_i,
  input logic                     rd_en_i,
  input logic [REG_AW-1:0]        rd_addr_i,
  input logic [63:0]              rd_data_o,
  input logic                     prohibit_i,
  input logic                     glb_en,
  input logic                     stop_en,
  input logic [N_EVT-1:0]         en_evt,
  input logic                     en_cyc,
  input logic [63:0]              cyc_q,
  input logic [N_EVT*CNT_W-1:0]   evt_flat
);
  logic wr_cyc;
  assign wr_cyc = wr_en_i && (wr_addr_i == REG_AW'(CYC_IDX));

  // R12: a write to the cycle counter lands exactly
  p_cyc_load_r12: assert property (@(posedge clk) disable iff (rst)
    wr_cyc |=> cyc_q == $past(wr_data_i));

  // R10: without a write the cycle counter holds or steps by one
  p_cyc_step_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_cyc |=> (cyc_q == $past(cyc_q)) || (cyc_q == $past(cyc_q) + 64'd1));

  // R5: master enable off freezes the cycle counter
  p_master_off_r5: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !wr_cyc) |=> $stable(cyc_q));

  // R9: stop bit with prohibit freezes the cycle counter
  p_stop_cyc_r9: assert property (@(posedge clk) disable iff (rst)
    (prohibit_i && stop_en && !wr_cyc) |=> $stable(cyc_q));

  // R4: enable bits are never cleared by a write
  p_enset_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(en_evt) & ~en_evt) == '0) && (en_cyc || !$past(en_cyc))));

  // R2: configuration reads have a zero upper half
  p_cfg_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i[6:5] != 2'b00) |=> rd_data_o[63:32] == 32'd0);

  for (genvar g = 0; g < N_EVT; g++) begin : g_chk
    logic wr_this;
    assign wr_this = wr_en_i && (wr_addr_i == REG_AW'(g));

    // R9: prohibit freezes every event counter
    p_evt_prohibit_r9: assert property (@(posedge clk) disable iff (rst)
      (prohibit_i && !wr_this) |=> $stable(evt_flat[g*CNT_W +: CNT_W]));

    // R3: an event counter steps by at most one per cycle
    p_evt_step_r3: assert property (@(posedge clk) disable iff (rst)
      !wr_this |=> (evt_flat[g*CNT_W +: CNT_W] == $past(evt_flat[g*CNT_W +: CNT_W]))
                || (evt_flat[g*CNT_W +: CNT_W] == $past(evt_flat[g*CNT_W +: CNT_W]) + CNT_W'(1)));
  end
endmodule

bind pmc_bank pmc_bank_chk #(.N_EVT(N_EVT), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .prohibit_i (prohibit_i),
  .glb_en     (glb_en),
  .stop_en    (stop_en),
  .en_evt     (en_evt),
  .en_cyc     (en_cyc),
  .cyc_q      (cyc_q),
  .evt_flat   (evt_flat)
);

// File: tb/tb_pmc_bank.sv
module tb_pmc_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int CW  = 32;
  localparam int EW  = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  lvl;
  logic        nsec;
  logic        proh;
  logic [EW-1:0] evt;
  logic        wr_en;
  logic [6:0]  wr_addr;
  logic [63:0] wr_data;
  logic        rd_en;
  logic [6:0]  rd_addr;
  logic [63:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmc_bank #(.N_EVT(N), .CNT_W(CW), .EVT_W(EW)) dut (
    .clk(clk), .rst(rst), .lvl_i(lvl), .nsec_i(nsec), .prohibit_i(proh),
    .evt_i(evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  // behavioural model
  logic [CW-1:0] m_cnt [N];
  logic [63:0]   m_cyc;
  logic [31:0]   m_type [N];
  logic [31:0]   m_cflt;
  logic [31:0]   m_en;
  logic          m_e, m_dp;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit evt_all = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [6:0] rot_q[$];
  int rot_ptr = 0;

  function automatic bit allow(logic [31:0] w, logic [1:0] l, logic ns);
    bit p = w[31], nsk = w[29], nsh = w[27], mm = w[26], sh = w[24];
    if (l == 0) return 1;
    if (l == 3) return mm == p;
    if (l == 1) return ns ? (nsk == p) : !p;
    return ns ? nsh : (sh != nsh);
  endfunction

  function automatic logic [63:0] m_read(logic [6:0] a);
    if (a < N) return 64'(m_cnt[a]);
    if (a == 31) return m_cyc;
    if (a >= 32 && a < 32 + N) return {32'd0, m_type[a-32]};
    if (a == 63) return {32'd0, m_cflt};
    if (a == 64) return {32'd0, m_en};
    if (a == 65) return {58'd0, m_dp, 4'd0, m_e};
    return 64'd0;
  endfunction

  task automatic m_update();
    bit inc [N];
    bit cinc;
    for (int i = 0; i < N; i++) begin
      int en_num = int'(m_type[i][15:0]);
      inc[i] = m_e && m_en[i] && allow(m_type[i], lvl, nsec) && !proh
               && en_num < EW && evt[en_num % EW];
    end
    cinc = m_e && m_en[31] && allow(m_cflt, lvl, nsec) && !(m_dp && proh);
    for (int i = 0; i < N; i++) begin
      if (wr_en && wr_addr == 7'(i)) m_cnt[i] = wr_data[CW-1:0];
      else if (inc[i]) m_cnt[i] = m_cnt[i] + 1;
    end
    if (wr_en && wr_addr == 7'd31) m_cyc = wr_data;
    else if (cinc) m_cyc = m_cyc + 64'd1;
    if (wr_en) begin
      for (int i = 0; i < N; i++)
        if (wr_addr == 7'(32 + i)) m_type[i] = wr_data[31:0] & 32'hAD00_FFFF;
      if (wr_addr == 7'd63) m_cflt = wr_data[31:0] & 32'hAD00_FFFF;
      if (wr_addr == 7'd64) m_en = m_en | (wr_data[31:0] & (32'h8000_0000 | ((32'd1 << N) - 1)));
      if (wr_addr == 7'd65) begin m_e = wr_data[0]; m_dp = wr_data[5]; end
    end
  endtask

  task automatic check(string tag, logic [6:0] a, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d act=%h exp=%h", tag, a, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [63:0] exp_v;
    logic [6:0]  a;
    bit          chk;
    chk = rd_en; a = rd_addr; exp_v = m_read(rd_addr);
    m_update();
    @(negedge clk);
    if (chk) check(tag, a, rd_data, exp_v);
    wr_en = 0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    evt = evt_all ? '1 : lfsr;
  endtask

  task automatic idle(int k, string tag);
    for (int i = 0; i < k; i++) begin
      rd_en = 1;
      rd_addr = rot_q[rot_ptr % rot_q.size()];
      rot_ptr++;
      step(tag);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [63:0] d, string tag);
    wr_en = 1; wr_addr = a; wr_data = d;
    idle(1, tag);
  endtask

  task automatic rd(logic [6:0] a, string tag);
    rd_en = 1; rd_addr = a;
    step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] fl [9];
    fl = '{32'h0, 32'h8000_0000, 32'h2000_0000, 32'hA000_0000, 32'h0800_0000,
           32'h0100_0000, 32'h0900_0000, 32'h0400_0000, 32'h8400_0000};
    for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_type[i] = '0; end
    m_cyc = '0; m_cflt = '0; m_en = '0; m_e = 0; m_dp = 0;
    rst = 1; lvl = 0; nsec = 1; proh = 0; evt = '0;
    wr_en = 0; wr_addr = '0; wr_data = '0; rd_en = 0; rd_addr = '0;
    rot_q = '{7'd0, 7'd1, 7'd2, 7'd3, 7'd31};
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: all state zero after reset
    foreach (rot_q[i]) rd(rot_q[i], "R1");
    rd(7'd32, "R1"); rd(7'd35, "R1"); rd(7'd63, "R1"); rd(7'd64, "R1"); rd(7'd65, "R1");

    // R4: nothing counts before enable-set bits are written
    wr(7'd65, 64'h1, "R4");
    wr(7'd32, 64'd0, "R4");
    wr(7'd33, 64'd5, "R4");
    wr(7'd34, 64'd20, "R3");
    wr(7'd35, 64'h403, "R3");
    evt_all = 1; evt = '1;
    idle(6, "R4");
    wr(7'd64, 64'h1, "R4");
    idle(6, "R4");
    wr(7'd64, 64'h0, "R4");
    idle(6, "R4");
    rd(7'd64, "R4");
    wr(7'd64, '1, "R4");
    rd(7'd64, "R2");

    // R3: varying event patterns
    evt_all = 0;
    idle(40, "R3");

    // R2: field masking and unmapped addresses
    wr(7'd35, '1, "R2");
    rd(7'd35, "R2");
    wr(7'd65, '1, "R2");
    rd(7'd65, "R2");
    wr(7'd65, 64'h1, "R2");
    wr(7'd80, '1, "R2");
    rd(7'd80, "R2"); rd(7'd16, "R2"); rd(7'd40, "R2");

    // R6 R7 R8: filter sweep over all levels and security states
    evt_all = 1;
    rot_q = '{7'd0, 7'd31};
    foreach (fl[f]) begin
      wr(7'd32, {32'd0, fl[f]}, "R6");
      wr(7'd63, {32'd0, fl[f]}, "R6");
      for (int l = 0; l < 4; l++) begin
        for (int s = 0; s < 2; s++) begin
          lvl = 2'(l); nsec = 1'(s);
          idle(2, l == 3 ? "R8" : (l == 2 ? "R7" : "R6"));
        end
      end
    end
    lvl = 0; nsec = 1;
    wr(7'd32, 64'd0, "R6");
    wr(7'd63, 64'd0, "R10");

    // R9: prohibit with the stop bit clear, then set
    rot_q = '{7'd0, 7'd1, 7'd31};
    proh = 1;
    idle(8, "R9");
    wr(7'd65, 64'h21, "R9");
    idle(8, "R9");
    proh = 0;
    idle(4, "R9");

    // R5: master enable off
    wr(7'd65, 64'h20, "R5");
    idle(8, "R5");
    wr(7'd65, 64'h1, "R5");

    // R11: wrap of both counter widths
    wr(7'd0, 64'hFFFF_FFFF, "R11");
    wr(7'd31, 64'hFFFF_FFFF_FFFF_FFFE, "R11");
    idle(4, "R11");

    // R12: write beats a same-cycle increment
    wr(7'd0, 64'h55, "R12");
    rd(7'd0, "R12");
    wr(7'd31, 64'h1234, "R12");
    rd(7'd31, "R12");

    // R10: long cycle-counter run
    evt_all = 0;
    idle(20, "R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule